// File: doc/BRIEF.md
# Registered Dual Binary/Gray Up-Counter

This block is a synchronous up-counter that keeps two registers advancing together on the same clock edge. One register holds the plain binary count. The other holds the Gray-coded form of that count. The Gray value is formed from the binary counter's next-state value and captured in its own flip-flops. It is never decoded from the registered binary outputs, so the Gray output carries no decoding glitches.

The Gray output is meant to serve as a pointer in an asynchronous FIFO. A pointer from one clock domain can be compared for equality with a pointer from another domain to detect full or empty, and no transient false match can occur because only one bit moves per count. The synchronizers and the FIFO storage live outside this block.

Each cycle the counter takes one of three actions, chosen in priority order:
- clear, when reset is high;
- step, when the increment enable is high;
- hold, otherwise.

Top module: `dual_gray_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, both `bin_q` and `gray_q` read zero after that edge. This holds whatever the value of `inc_en`.
- R2: When `rst` is low and `inc_en` is high at a rising edge, `bin_q` becomes its previous value plus one, modulo 2^W.
- R3: When `rst` and `inc_en` are both low at a rising edge, `bin_q` and `gray_q` keep their values.
- R4: After every edge, `gray_q` equals `bin_q ^ (bin_q >> 1)`. Bit i is `bin_q[i] ^ bin_q[i+1]`, and the top bit equals `bin_q[W-1]`. The Gray value is never one cycle behind the binary value.
- R5: On every step, exactly one bit of `gray_q` changes.
- R6: A step from all ones wraps `bin_q` to zero. At that wrap, `gray_q` goes from only its top bit set to zero, which is again a single-bit change.
- R7: The width W is a parameter with a default of 4 bits. W must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; overrides `inc_en` |
| inc_en | input | 1 | Advance the count by one on this edge |
| bin_q | output | W | Registered binary count |
| gray_q | output | W | Registered Gray code of the count |

## Verification
Some properties are checked by the assertions on every cycle:
- the Gray register always matches the Gray form of the binary register;
- a step moves exactly one Gray bit and adds one to the binary count;
- a hold leaves both registers unchanged;
- reset clears both registers.

Other behaviour only the bench scenarios can show. These are a long run of random enables and resets scored against an independent model, a reset applied while the enable is high, and a full pass through all 2^W states ending in the wrap. Together they show that the sequence of values is the right one, not merely one that is self-consistent.

// File: rtl/dgc_pkg.sv
package dgc_pkg;

    // Action taken by the counter on a clock edge, in priority order.
    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_HOLD  = 2'd2
    } dgc_action_e;

endpackage

// File: rtl/dgc_next.sv
module dgc_next
    import dgc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         rst,
    input  logic         inc_en,
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    dgc_action_e act;

    // Pick the action: reset first, then increment, otherwise hold.
    always_comb begin
        if (rst)         act = ACT_CLEAR;
        else if (inc_en) act = ACT_STEP;
        else             act = ACT_HOLD;
    end

    // Binary next-state value; wraps naturally at 2^W.
    always_comb begin
        unique case (act)
            ACT_CLEAR: nxt = ZERO;
            ACT_STEP:  nxt = cur + ONE;
            ACT_HOLD:  nxt = cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/dgc_gray_conv.sv
module dgc_gray_conv #(
    parameter int W = 4
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] gray
);
    // Top bit passes through unchanged.
    assign gray[W-1] = bin[W-1];

    // Each lower bit is the XOR of two neighbouring binary bits.
    for (genvar i = 0; i < W - 1; i++) begin : g_xor
        assign gray[i] = bin[i] ^ bin[i+1];
    end
endmodule

// File: rtl/dgc_reg.sv
module dgc_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Plain flip-flops; the clear is already folded into d.
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/dual_gray_counter.sv
module dual_gray_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_en,
    output logic [W-1:0] bin_q,
    output logic [W-1:0] gray_q
);
    logic [W-1:0] bin_d;
    logic [W-1:0] gray_d;

    // Binary next state.
    dgc_next #(.W(W)) u_next (
        .rst    (rst),
        .inc_en (inc_en),
        .cur    (bin_q),
        .nxt    (bin_d)
    );

    // Gray code formed from the next state, not from the registered count.
    dgc_gray_conv #(.W(W)) u_conv (
        .bin  (bin_d),
        .gray (gray_d)
    );

    // Binary register.
    dgc_reg #(.W(W)) u_bin_reg (
        .clk (clk),
        .d   (bin_d),
        .q   (bin_q)
    );

    // Gray register, loaded on the same edge as the binary register.
    dgc_reg #(.W(W)) u_gray_reg (
        .clk (clk),
        .d   (gray_d),
        .q   (gray_q)
    );
endmodule

// File: rtl/dgc_checker.sv
module dgc_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         inc_en,
    input logic [W-1:0] bin_q,
    input logic [W-1:0] gray_q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (bin_q == '0 && gray_q == '0));                                   // R1

    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
        inc_en |=> bin_q == $past(bin_q) + ONE);                                  // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !inc_en |=> ($stable(bin_q) && $stable(gray_q)));                         // R3

    AST_GRAY_MATCH: assert property (@(posedge clk) disable iff (rst)
        gray_q == (bin_q ^ (bin_q >> 1)));                                        // R4

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        inc_en |=> $countones(gray_q ^ $past(gray_q)) == 1);                      // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (inc_en && (&bin_q)) |=> (bin_q == '0 && gray_q == '0));                  // R6
endmodule

bind dual_gray_counter dgc_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .inc_en (inc_en),
    .bin_q  (bin_q),
    .gray_q (gray_q)
);

// File: tb/dual_gray_counter_tb.sv
module dual_gray_counter_tb;
    localparam int W = 4;
    localparam int MAXCYC = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inc_en = 1'b0;
    logic [W-1:0] bin_q;
    logic [W-1:0] gray_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [W-1:0] m_bin;
    logic [W-1:0] prev_gray;

    always #2.5 clk = ~clk;   // 200 MHz

    dual_gray_counter #(.W(W)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .inc_en (inc_en),
        .bin_q  (bin_q),
        .gray_q (gray_q)
    );

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        logic [W-1:0] g;
        g[W-1] = b[W-1];
        for (int i = 0; i < W - 1; i++) g[i] = b[i] ^ b[i+1];
        return g;
    endfunction

    function automatic int ones(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass, sample 1 ns later.
    task automatic step(input logic r, input logic e, input string req);
        @(negedge clk);
        rst = r;
        inc_en = e;
        prev_gray = gray_q;
        @(posedge clk);
        #1;
        if (r)      m_bin = '0;
        else if (e) m_bin = m_bin + 1'b1;
        chk(req, bin_q, m_bin);
        chk("R4", gray_q, to_gray(m_bin));
        if (!r && e) begin
            total++;
            if (ones(gray_q ^ prev_gray) != 1) begin
                bad++;
                $display("FAIL R5: actual=%0d expected=1 bits changed",
                         ones(gray_q ^ prev_gray));
            end
        end
    endtask

    initial begin
        #(MAXCYC * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_bin = '0;
        void'($urandom(32'd2718));

        // R1: reset state
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");

        // R2: a few directed steps
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R2");

        // R3: hold for several cycles
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R3");

        // R1: reset wins over the enable
        step(1'b1, 1'b1, "R1");

        // R6: full pass through every state, ending in the wrap
        for (int i = 0; i < (1 << W); i++) step(1'b0, 1'b1, "R6");
        chk("R6", bin_q, '0);

        // Hold at all ones, then wrap.
        for (int i = 0; i < (1 << W) - 1; i++) step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R3");
        chk("R6", gray_q, {1'b1, {(W-1){1'b0}}});
        step(1'b0, 1'b1, "R6");

        // R7: random mix at the default width
        for (int i = 0; i < 400; i++) begin
            automatic int r = $urandom_range(0, 99);
            if (r < 3)       step(1'b1, ($urandom_range(0, 1) == 1), "R1");
            else if (r < 70) step(1'b0, 1'b1, "R2");
            else             step(1'b0, 1'b0, "R3");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule